// File: doc/BRIEF.md
# Gated-Clock Parallel-In Serial-Out Shift Register

This block is an eight-stage shift register. It can take a whole word in parallel, or move its contents one place per clock pulse toward its last stage, and it presents that last stage on a true output and an inverted output. It does not use the pulse inputs as real clocks. The whole block runs on one system clock. The two pulse inputs and the active-low load control come from outside that clock domain, so each passes through a synchronizer first. A shift is then taken as the system cycle in which the synchronized OR of the two pulse inputs goes from low to high.

The two pulse inputs are equivalent. Either one can carry the shift pulses while the other stays low. Holding either one high keeps the combined clock high, so no rising edge can occur and the register is frozen. While the synchronized load control is low, the parallel word is written into every stage on each cycle, and any shift edge in that cycle is ignored. Parallel loading therefore acts as a level, not as a clocked event.

Top module: `piso_gated_shreg`

## Requirements
- R1: While `rst_ni` is low, all stages are zero, so `q_last_o` is 0 and `q_last_no` is 1.
- R2: While the synchronized `load_ni` is low, every stage takes its bit of `par_i`. `par_i[0]` goes to the first stage and `par_i[WIDTH-1]` goes to the last stage, which drives `q_last_o`.
- R3: A load has priority. While `load_ni` is low, edges on `sclk_a_i` or `sclk_b_i` do not shift, and the stages keep following `par_i`.
- R4: With `load_ni` high, a rising edge of the synchronized (`sclk_a_i` OR `sclk_b_i`) moves stage k into stage k+1 and loads `ser_i` into the first stage.
- R5: While either pulse input stays high, no shift happens, whatever the other pulse input does.
- R6: Either pulse input works as the shift clock while the other is held low.
- R7: With `load_ni` high and no rising edge of the combined clock, all stages hold their values. Changes on `par_i` or `ser_i` alone have no effect.
- R8: `q_last_no` is always the inverse of `q_last_o`.
- R9: A change on `sclk_a_i`, `sclk_b_i` or `load_ni` reaches the outputs on the third rising system-clock edge after it is applied. After the second edge the outputs still show the old value.
- R10: No shift takes place in the first system cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| load_ni | input | 1 | Active-low parallel load; high enables shifting |
| par_i | input | WIDTH | Parallel word, bit 0 to the first stage |
| ser_i | input | 1 | Serial data into the first stage |
| sclk_a_i | input | 1 | Shift pulse input, also inhibits while high |
| sclk_b_i | input | 1 | Shift pulse input, interchangeable with sclk_a_i |
| q_last_o | output | 1 | Last stage |
| q_last_no | output | 1 | Inverse of the last stage |

## Verification
The properties assume the following about the inputs:
- `par_i` and `ser_i` are steady in the cycle a synchronized load or shift samples them.
- A pulse input counts as held high only if it has been high for the last four system cycles.
- Reset was released at least three cycles before such a window starts.

The stimulus meets these assumptions by construction. It changes only one input at a time, on the falling edge of the system clock. After each change it waits four system cycles before the next change or check, so every change has passed through the synchronizers before anything else moves.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } stage_op_e;
endpackage

// File: rtl/piso_sync.sv
`timescale 1ns/1ps
// Single-bit flop chain that brings an asynchronous level into clk_i.
module piso_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  assign chain_d[0] = d_i;
  for (genvar g = 1; g < STAGES; g++) begin : g_chain
    assign chain_d[g] = chain_q[g-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
    else         chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/piso_ctrl.sv
`timescale 1ns/1ps
// Combines the synchronized pulse inputs, finds rising edges, picks the stage operation.
module piso_ctrl
  import piso_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clk_a_s_i,
  input  logic      clk_b_s_i,
  input  logic      load_n_s_i,
  output stage_op_e op_o
);
  logic eff_clk;
  logic eff_q;
  logic eff_d;
  logic eff_rise;

  // Either pulse input high keeps the combined clock high, which inhibits edges.
  assign eff_clk = clk_a_s_i | clk_b_s_i;
  assign eff_d   = eff_clk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eff_q <= 1'b0;
    else         eff_q <= eff_d;
  end

  assign eff_rise = eff_clk & ~eff_q;

  always_comb begin
    if (!load_n_s_i)   op_o = OP_LOAD;   // load wins over a coincident edge
    else if (eff_rise) op_o = OP_SHIFT;
    else               op_o = OP_HOLD;
  end
endmodule

// File: rtl/piso_stages.sv
`timescale 1ns/1ps
// Storage stages with parallel load and a one-place shift toward the top index.
module piso_stages
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  stage_op_e        op_i,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  output logic [WIDTH-1:0] stage_o
);
  logic [WIDTH-1:0] stage_q;
  logic [WIDTH-1:0] stage_d;
  logic [WIDTH-1:0] shifted;
  logic             upd_en;

  assign shifted[0] = ser_i;
  for (genvar g = 1; g < WIDTH; g++) begin : g_shift
    assign shifted[g] = stage_q[g-1];
  end

  always_comb begin
    unique case (op_i)
      OP_LOAD:  stage_d = par_i;
      OP_SHIFT: stage_d = shifted;
      default:  stage_d = stage_q;
    endcase
    upd_en = (op_i != OP_HOLD);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (upd_en) stage_q <= stage_d;
  end

  assign stage_o = stage_q;
endmodule

// File: rtl/piso_gated_shreg.sv
`timescale 1ns/1ps
module piso_gated_shreg
  import piso_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_ni,
  input  logic [WIDTH-1:0] par_i,
  input  logic             ser_i,
  input  logic             sclk_a_i,
  input  logic             sclk_b_i,
  output logic             q_last_o,
  output logic             q_last_no
);
  localparam int                   NUM_ASYNC = 3;
  localparam int                   IDX_A     = 0;
  localparam int                   IDX_B     = 1;
  localparam int                   IDX_LD    = 2;
  // The load control resets to its idle (high) level; the pulse inputs reset low.
  localparam logic [NUM_ASYNC-1:0] ASYNC_RST = NUM_ASYNC'(1) << IDX_LD;

  logic [NUM_ASYNC-1:0] async_raw;
  logic [NUM_ASYNC-1:0] async_sync;
  stage_op_e            op;
  logic [WIDTH-1:0]     stage_q;

  assign async_raw[IDX_A]  = sclk_a_i;
  assign async_raw[IDX_B]  = sclk_b_i;
  assign async_raw[IDX_LD] = load_ni;

  for (genvar g = 0; g < NUM_ASYNC; g++) begin : g_sync
    piso_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (ASYNC_RST[g])
    ) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (async_raw[g]),
      .q_o    (async_sync[g])
    );
  end

  piso_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clk_a_s_i  (async_sync[IDX_A]),
    .clk_b_s_i  (async_sync[IDX_B]),
    .load_n_s_i (async_sync[IDX_LD]),
    .op_o       (op)
  );

  piso_stages #(
    .WIDTH (WIDTH)
  ) u_stages (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .op_i    (op),
    .par_i   (par_i),
    .ser_i   (ser_i),
    .stage_o (stage_q)
  );

  assign q_last_o  = stage_q[WIDTH-1];
  assign q_last_no = ~stage_q[WIDTH-1];
endmodule

// File: rtl/piso_gated_shreg_chk.sv
`timescale 1ns/1ps
module piso_gated_shreg_chk
  import piso_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] par_i,
  input logic             ser_i,
  input logic             sclk_a_i,
  input logic             sclk_b_i,
  input stage_op_e        op,
  input logic [WIDTH-1:0] stage_q,
  input logic             q_last_o,
  input logic             q_last_no
);
  assert_out_inverse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_last_no == ~q_last_o);

  assert_load_copy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_LOAD) |=> stage_q == $past(par_i));

  assert_shift_move_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_SHIFT) |=> stage_q == {$past(stage_q[WIDTH-2:0]), $past(ser_i)});

  assert_hold_still_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_HOLD) |=> $stable(stage_q));

  assert_inhibit_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) &&
     ((sclk_a_i && $past(sclk_a_i) && $past(sclk_a_i, 2) && $past(sclk_a_i, 3)) ||
      (sclk_b_i && $past(sclk_b_i) && $past(sclk_b_i, 2) && $past(sclk_b_i, 3))))
    |-> (op != OP_SHIFT));

  assert_quiet_start_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (op != OP_SHIFT));
endmodule

bind piso_gated_shreg piso_gated_shreg_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .par_i     (par_i),
  .ser_i     (ser_i),
  .sclk_a_i  (sclk_a_i),
  .sclk_b_i  (sclk_b_i),
  .op        (op),
  .stage_q   (stage_q),
  .q_last_o  (q_last_o),
  .q_last_no (q_last_no)
);

// File: tb/piso_gated_shreg_bench.sv
`timescale 1ns/1ps
module piso_gated_shreg_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         ld_n;
  logic [W-1:0] par;
  logic         ser;
  logic         ca;
  logic         cb;
  logic         qh;
  logic         qhn;

  logic [W-1:0] mdl;
  int           n_chk = 0;
  int           n_bad = 0;

  always #4 clk = ~clk;

  piso_gated_shreg #(.WIDTH(W), .SYNC_STAGES(2)) u_piso_gated_shreg (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .load_ni   (ld_n),
    .par_i     (par),
    .ser_i     (ser),
    .sclk_a_i  (ca),
    .sclk_b_i  (cb),
    .q_last_o  (qh),
    .q_last_no (qhn)
  );

  function automatic logic [W-1:0] shift_fn(logic [W-1:0] s, logic d);
    return {s[W-2:0], d};
  endfunction

  task automatic check(string req, logic exp);
    n_chk++;
    if (qh !== exp || qhn !== ~exp) begin
      n_bad++;
      $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", req, qh, qhn, exp, ~exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_clk(bit which_b, logic v);
    logic old_or;
    old_or = ca | cb;
    if (which_b) cb = v; else ca = v;
    if (ld_n && (ca | cb) && !old_or) mdl = shift_fn(mdl, ser);
    settle();
  endtask

  task automatic set_load(logic v);
    ld_n = v;
    if (!v) mdl = par;
    settle();
  endtask

  task automatic set_par(logic [W-1:0] v);
    par = v;
    if (!ld_n) mdl = par;
    settle();
  endtask

  task automatic set_ser(logic v);
    ser = v;
    settle();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ld_n = 1'b1; par = '0; ser = 1'b1; ca = 1'b0; cb = 1'b0;
    mdl = '0;
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    settle();
    check("R10", 1'b0);

    // R2: parallel load
    set_par(8'b1010_0110);
    set_load(1'b0);
    check("R2", 1'b1);
    // R3: edges during load do nothing, stages follow par
    set_clk(1'b0, 1'b1);
    check("R3", 1'b1);
    set_clk(1'b0, 1'b0);
    set_clk(1'b1, 1'b1);
    set_clk(1'b1, 1'b0);
    check("R3", 1'b1);
    set_par(8'b0110_0110);
    check("R3", 1'b0);
    set_par(8'b1010_0110);
    check("R2", 1'b1);
    set_load(1'b1);
    check("R2", mdl[W-1]);

    // R9: latency of a shift through the synchronizer
    set_ser(1'b0);
    ca = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R9", 1'b1);
    @(negedge clk);
    check("R9", 1'b0);
    mdl = shift_fn(mdl, ser);
    settle();
    set_clk(1'b0, 1'b0);

    // R6: second pulse input alone drives shifting
    for (int i = 0; i < W; i++) begin
      set_ser(1'(i & 1));
      set_clk(1'b1, 1'b1);
      check("R6", mdl[W-1]);
      set_clk(1'b1, 1'b0);
      check("R6", mdl[W-1]);
    end

    // R5: either pulse input held high inhibits
    set_clk(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) begin
      set_clk(1'b1, 1'b1);
      set_clk(1'b1, 1'b0);
      check("R5", mdl[W-1]);
    end
    set_clk(1'b1, 1'b1);
    set_clk(1'b0, 1'b0);
    set_clk(1'b0, 1'b1);
    set_clk(1'b0, 1'b0);
    check("R5", mdl[W-1]);
    set_clk(1'b1, 1'b0);

    // R7: data inputs alone are ignored
    set_par(~mdl);
    check("R7", mdl[W-1]);
    set_ser(~ser);
    check("R7", mdl[W-1]);

    // R4 and friends: random single-input changes against the model
    void'($urandom(32'd20240917));
    for (int i = 0; i < 400; i++) begin
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0: set_clk(1'b0, ~ca);
        1: set_clk(1'b1, ~cb);
        2: if (!ld_n) set_load(1'b1);
           else if (($urandom % 4) == 0) set_load(1'b0);
           else set_clk(1'b0, ~ca);
        3: set_par(W'($urandom));
        4: set_ser(1'($urandom));
        default: set_clk(1'b1, ~cb);
      endcase
      check("R4", mdl[W-1]);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule